// File: doc/BRIEF.md
# Multi-Channel Prescaled Pulse-Width Modulator

This block drives a set of independent pulse-width-modulated outputs. A host programs them over a simple 32-bit register bus, which it addresses by word. Each channel has a 16-bit period counter, and a prescaler advances that counter. The prescaler divides the block clock by a power of two taken from a fixed, non-uniform set of shifts. Two counts form a window inside each period. The output takes one programmable level while the counter is inside that window and another level while it is outside.

Settings are double-buffered. Software first writes the window word and then the period word. The write to the period word arms a transfer, and the transfer happens only when the running counter wraps, so a period already in progress always finishes with its old shape. A channel that is switched off holds its counter at zero and keeps its output low. While it is off, it follows its programmed settings directly, so it starts cleanly from count zero when it is switched on.

One shared enable register carries a bit for each channel. Every register also answers at three companion addresses that set, clear or invert individual bits. Software can therefore change one field or one channel without a read-modify-write.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads 0 and every output is low.
- R2: The enable register sits at byte offset 0x0. The window word of channel n sits at 0x10+n*0x20 and the period word of channel n at 0x20+n*0x20. A read returns the stored value. Period-word bits 31:23 are not stored and read as 0.
- R3: Each register answers at four byte offsets from its base. +0x0 replaces the value. +0x4 sets the bits that are 1 in the written data. +0x8 clears them. +0xC inverts them.
- R4: Period-word bits 15:0 give the period length P in prescaled ticks. The counter runs 0..P-1 and then wraps to 0. A value of 0 means 65536.
- R5: The window word holds the start count in bits 15:0 and the end count in bits 31:16. The channel is in its active phase while start <= count < end, and in its inactive phase otherwise.
- R6: Period-word bits 17:16 give the level code for the active phase, and bits 19:18 give the code for the inactive phase. Code 3 drives the output high. Codes 2, 1 and 0 drive it low.
- R7: Period-word bits 22:20 hold a prescaler index k from 0 to 7. The counter advances once every 2^s block clocks, with s taken as 0,1,2,3,4,6,8,10 for k = 0..7.
- R8: On an enabled channel, new window and period values reach the waveform only at the first counter wrap after a period-word write. A write to the window word alone leaves the running waveform unchanged.
- R9: Enable register bit n switches channel n on. A disabled channel holds its counter and prescaler at zero, drives its output low and takes its settings immediately, so after enabling it starts at count 0 with the current settings.
- R10: Channels run independently. Changing or disabling one channel does not alter the output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one word per cycle |
| busAddr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | NUM_CH | One modulated output per channel |

## Verification
The embedded properties check the following on every cycle:
- The set and clear aliases of the enable register take effect.
- A disabled channel's counter and prescaler sit at zero.
- The counter never passes its period limit and returns to zero after a wrap.
- A period-word write always arms a transfer.
- The working settings hold still between transfers.

Some behaviour is visible only in the bench's directed scenarios, which count high cycles over whole periods. These scenarios show the actual duty, the level encodings, the prescaler shift table, the 65536-cycle period, the deferred commit after a mid-period update, the immediate load while disabled, and independence between channels.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int CNT_W  = 16;
  localparam int PSC_W  = 10;
  localparam int PER_W  = 23;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_INVERT = 2'd3
  } busOp_t;

  typedef struct packed {
    logic enable;
    logic armLoad;
  } chanCtl_t;

  function automatic logic [3:0] prescaleShift(input logic [2:0] idx);
    logic [3:0] s;
    case (idx)
      3'd0: s = 4'd0;
      3'd1: s = 4'd1;
      3'd2: s = 4'd2;
      3'd3: s = 4'd3;
      3'd4: s = 4'd4;
      3'd5: s = 4'd6;
      3'd6: s = 4'd8;
      default: s = 4'd10;
    endcase
    return s;
  endfunction

  function automatic logic [31:0] applyOp(input busOp_t op,
                                          input logic [31:0] oldVal,
                                          input logic [31:0] data);
    logic [31:0] r;
    case (op)
      OP_WRITE:  r = data;
      OP_SET:    r = oldVal | data;
      OP_CLEAR:  r = oldVal & ~data;
      default:   r = oldVal ^ data;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:2]            addr,
  input  logic [31:0]                  wrData,
  output logic [31:0]                  rdData,
  output logic [NUM_CH-1:0][31:0]      shadowActive,
  output logic [NUM_CH-1:0][PER_W-1:0] shadowPeriod,
  output chanCtl_t [NUM_CH-1:0]        ctl
);

  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]  regIdx;
  busOp_t            op;
  logic              isCtrl;
  logic [NUM_CH-1:0] ctrlQ;
  logic [31:0]       ctrlNext;

  assign regIdx = addr[ADDR_W-1:4];
  assign op     = busOp_t'(addr[3:2]);
  assign isCtrl = (regIdx == '0);

  assign ctrlNext = applyOp(op, 32'(ctrlQ), wrData);

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (wrEn && isCtrl) ctrlQ <= ctrlNext[NUM_CH-1:0];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    logic        hitAct, hitPer;
    logic [31:0] actNext, perNext;

    assign hitAct  = (regIdx == IDX_W'(2*n + 1));
    assign hitPer  = (regIdx == IDX_W'(2*n + 2));
    assign actNext = applyOp(op, shadowActive[n], wrData);
    assign perNext = applyOp(op, 32'(shadowPeriod[n]), wrData);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowActive[n] <= '0;
        shadowPeriod[n] <= '0;
      end else if (wrEn) begin
        if (hitAct) shadowActive[n] <= actNext;
        if (hitPer) shadowPeriod[n] <= perNext[PER_W-1:0];
      end
    end

    assign ctl[n].enable  = ctrlQ[n];
    assign ctl[n].armLoad = wrEn && hitPer;
  end

  always_comb begin
    rdData = '0;
    if (isCtrl) rdData = 32'(ctrlQ);
    for (int n = 0; n < NUM_CH; n++) begin
      if (regIdx == IDX_W'(2*n + 1)) rdData = shadowActive[n];
      if (regIdx == IDX_W'(2*n + 2)) rdData = 32'(shadowPeriod[n]);
    end
  end

  // R3: set alias leaves every written 1-bit set in the enable register
  p_ctrl_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isCtrl && op == OP_SET) |=>
      ((ctrlQ & $past(wrData[NUM_CH-1:0])) == $past(wrData[NUM_CH-1:0])));

  // R3: clear alias leaves every written 1-bit cleared
  p_ctrl_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isCtrl && op == OP_CLEAR) |=>
      ((ctrlQ & $past(wrData[NUM_CH-1:0])) == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanCtl_t         ctl,
  input  logic [31:0]      shadowActive,
  input  logic [PER_W-1:0] shadowPeriod,
  output logic             pwmOut
);

  logic [31:0]      workActive;
  logic [PER_W-1:0] workPeriod;
  logic [CNT_W-1:0] cntQ;
  logic [PSC_W-1:0] pscQ;
  logic             pendQ;

  logic [3:0]       shiftAmt;
  logic [PSC_W-1:0] pscMask;
  logic [CNT_W-1:0] lastCnt;
  logic             tick, wrap, commit, inWindow;
  logic [1:0]       levelCode;

  assign shiftAmt = prescaleShift(workPeriod[22:20]);
  assign pscMask  = ~({PSC_W{1'b1}} << shiftAmt);
  assign tick     = (pscQ == pscMask);
  assign lastCnt  = workPeriod[CNT_W-1:0] - CNT_W'(1);
  assign wrap     = tick && (cntQ == lastCnt);
  assign commit   = wrap && pendQ && !ctl.armLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workActive <= '0;
      workPeriod <= '0;
      cntQ       <= '0;
      pscQ       <= '0;
      pendQ      <= 1'b0;
    end else if (!ctl.enable) begin
      workActive <= shadowActive;
      workPeriod <= shadowPeriod;
      cntQ       <= '0;
      pscQ       <= '0;
      pendQ      <= 1'b0;
    end else begin
      pscQ  <= tick ? '0 : pscQ + PSC_W'(1);
      if (tick) cntQ <= wrap ? '0 : cntQ + CNT_W'(1);
      if (commit) begin
        workActive <= shadowActive;
        workPeriod <= shadowPeriod;
      end
      pendQ <= ctl.armLoad || (pendQ && !commit);
    end
  end

  assign inWindow  = (cntQ >= workActive[15:0]) && (cntQ < workActive[31:16]);
  assign levelCode = inWindow ? workPeriod[17:16] : workPeriod[19:18];
  assign pwmOut    = ctl.enable && (levelCode == 2'b11);

  // R9: disabled channel keeps counter and prescaler at zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.enable |=> (cntQ == '0 && pscQ == '0));

  // R4: counter never passes the last count of the period
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.enable |-> (cntQ <= lastCnt));

  // R4: a wrap returns the counter to zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && wrap) |=> (cntQ == '0));

  // R8: a period-word write always arms a transfer
  p_arm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && ctl.armLoad) |=> pendQ);

  // R8: working settings hold between transfers
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && !commit) |=> ($stable(workActive) && $stable(workPeriod)));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:2] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [NUM_CH-1:0] pwmOut
);

  localparam int SPAN = 32 * (NUM_CH + 1);

  initial begin
    if (SPAN > (1 << ADDR_W)) $error("ADDR_W too small for NUM_CH");
  end

  logic [NUM_CH-1:0][31:0]      shadowActive;
  logic [NUM_CH-1:0][PER_W-1:0] shadowPeriod;
  chanCtl_t [NUM_CH-1:0]        ctl;

  pwm_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (busWrEn),
    .addr         (busAddr),
    .wrData       (busWrData),
    .rdData       (busRdData),
    .shadowActive (shadowActive),
    .shadowPeriod (shadowPeriod),
    .ctl          (ctl)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    pwm_channel u_ch (
      .clk          (clk),
      .rstN         (rstN),
      .ctl          (ctl[n]),
      .shadowActive (shadowActive[n]),
      .shadowPeriod (shadowPeriod[n]),
      .pwmOut       (pwmOut[n])
    );
  end

endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;

  localparam int NUM_CH = 2;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:2] busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NUM_CH-1:0] pwmOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run exceeded cycle limit (actual %0d expected < 150000)", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [11:0] actAddr(input int ch);
    return 12'(16 + ch * 32);
  endfunction
  function automatic logic [11:0] perAddr(input int ch);
    return 12'(32 + ch * 32);
  endfunction
  function automatic logic [31:0] perWord(input int psc, input int inact,
                                          input int act, input int per);
    return 32'((psc << 20) | (inact << 18) | (act << 16) | (per & 16'hFFFF));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] byteAddr, input logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = byteAddr[11:2]; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] byteAddr, output logic [31:0] data);
    @(negedge clk);
    busAddr = byteAddr[11:2];
    #1 data = busRdData;
  endtask

  // count high samples of each output over n cycles, starting at the current negedge
  task automatic measure(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < n; i++) begin
      c0 += int'(pwmOut[0]);
      c1 += int'(pwmOut[1]);
      @(negedge clk);
    end
  endtask

  task automatic setup(input int ch, input int st, input int en, input logic [31:0] pw);
    busWrite(actAddr(ch), 32'((en << 16) | st));
    busWrite(perAddr(ch), pw);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    busRead(12'h000, d); check("R1 ctrl", d, 0);
    busRead(actAddr(0), d); check("R1 active0", d, 0);
    busRead(perAddr(1), d); check("R1 period1", d, 0);
    check("R1 outputs", 32'(pwmOut), 0);
  endtask

  task automatic test_aliases();
    logic [31:0] d;
    busWrite(12'h004, 32'h1); busWrite(12'h004, 32'h2);
    busRead(12'h000, d); check("R3 set alias", d, 32'h3);
    busWrite(12'h008, 32'h1);
    busRead(12'h000, d); check("R3 clear alias", d, 32'h2);
    busWrite(12'h00C, 32'h3);
    busRead(12'h000, d); check("R3 invert alias", d, 32'h1);
    busWrite(12'h000, 32'h0);
    busRead(12'h000, d); check("R3 plain write", d, 32'h0);
    busWrite(actAddr(1), 32'h1234_0000); busWrite(actAddr(1) + 12'h4, 32'h0000_00F0);
    busRead(actAddr(1), d); check("R3 set on window word", d, 32'h1234_00F0);
    busWrite(perAddr(0), 32'hFFFF_FFFF);
    busRead(perAddr(0), d); check("R2 period upper bits read 0", d, 32'h007F_FFFF);
    busWrite(perAddr(0) + 12'h8, 32'hFFFF_FFFF);
    busRead(perAddr(0), d); check("R2 R3 cleared period word", d, 0);
    busWrite(actAddr(1), 0);
  endtask

  task automatic test_duty();
    int c0, c1;
    setup(0, 0, 4, perWord(0, 2, 3, 10));
    busWrite(12'h004, 32'h1);
    check("R9 starts at count 0 (high)", 32'(pwmOut[0]), 1);
    measure(100, c0, c1); check("R4 R5 duty 4/10", c0, 40);
    busWrite(12'h008, 32'h1);
    setup(0, 3, 7, perWord(0, 2, 3, 10));
    busWrite(12'h004, 32'h1);
    check("R5 count 0 outside window", 32'(pwmOut[0]), 0);
    measure(3, c0, c1); check("R5 counts 0..2 low", c0, 0);
    measure(97, c0, c1); check("R5 window 3..6", c0, 40);
    busWrite(12'h008, 32'h1);
  endtask

  task automatic test_levels();
    int c0, c1;
    setup(0, 0, 4, perWord(0, 3, 2, 10));
    busWrite(12'h004, 32'h1);
    measure(100, c0, c1); check("R6 inverse levels", c0, 60);
    busWrite(12'h008, 32'h1);
    setup(0, 0, 4, perWord(0, 3, 0, 10));
    busWrite(12'h004, 32'h1);
    measure(100, c0, c1); check("R6 code 0 low", c0, 60);
    busWrite(12'h008, 32'h1);
    setup(0, 0, 4, perWord(0, 1, 3, 10));
    busWrite(12'h004, 32'h1);
    measure(100, c0, c1); check("R6 code 1 low", c0, 40);
    busWrite(12'h008, 32'h1);
  endtask

  task automatic test_prescale();
    int c0, c1;
    setup(0, 0, 1, perWord(5, 2, 3, 4));
    busWrite(12'h004, 32'h1);
    measure(64, c0, c1);  check("R7 index 5 high run", c0, 64);
    measure(192, c0, c1); check("R7 index 5 low run", c0, 0);
    measure(256, c0, c1); check("R7 index 5 next period", c0, 64);
    busWrite(12'h008, 32'h1);
    setup(0, 0, 1, perWord(7, 2, 3, 2));
    busWrite(12'h004, 32'h1);
    measure(1024, c0, c1); check("R7 index 7 high run", c0, 1024);
    measure(1024, c0, c1); check("R7 index 7 low run", c0, 0);
    busWrite(12'h008, 32'h1);
  endtask

  task automatic test_max_period();
    int c0, c1;
    setup(0, 0, 1, perWord(0, 2, 3, 0));
    busWrite(12'h004, 32'h1);
    measure(1, c0, c1);     check("R4 zero period first count", c0, 1);
    measure(65535, c0, c1); check("R4 zero period rest", c0, 0);
    measure(1, c0, c1);     check("R4 wrap after 65536", c0, 1);
    busWrite(12'h008, 32'h1);
  endtask

  task automatic test_buffering();
    int c0, c1, hA, hB;
    setup(0, 0, 4, perWord(0, 2, 3, 10));
    busWrite(12'h004, 32'h1);
    hA = 0; hB = 0;
    for (int i = 0; i < 20; i++) begin
      if (i < 10) hA += int'(pwmOut[0]); else hB += int'(pwmOut[0]);
      if (i == 2) begin busWrEn = 1'b1; busAddr = actAddr(0) >> 2; busWrData = 32'h0008_0000; end
      if (i == 3) begin busAddr = perAddr(0) >> 2; busWrData = perWord(0, 2, 3, 10); end
      if (i == 4) busWrEn = 1'b0;
      @(negedge clk);
    end
    check("R8 old shape until wrap", hA, 4);
    check("R8 new shape after wrap", hB, 8);
    busWrite(actAddr(0), 32'h0002_0000);
    measure(100, c0, c1); check("R8 window-only write ignored", c0, 80);
    // R9: disable then reload window only; disabled channel takes it at once
    busWrite(12'h008, 32'h1);
    measure(50, c0, c1); check("R9 disabled output low", c0, 0);
    busWrite(actAddr(0), 32'h0005_0000);
    busWrite(12'h004, 32'h1);
    measure(10, c0, c1); check("R9 immediate load while off", c0, 5);
    busWrite(12'h008, 32'h1);
  endtask

  task automatic test_independent();
    int c0, c1;
    setup(0, 0, 5, perWord(0, 2, 3, 10));
    setup(1, 0, 2, perWord(0, 2, 3, 8));
    busWrite(12'h004, 32'h3);
    measure(40, c0, c1);
    check("R10 channel 0 duty", c0, 20);
    check("R10 channel 1 duty", c1, 10);
    busWrite(12'h008, 32'h2);
    measure(40, c0, c1);
    check("R10 channel 0 unaffected", c0, 20);
    check("R9 R10 channel 1 off", c1, 0);
    busWrite(12'h008, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_aliases();
    test_duty();
    test_levels();
    test_prescale();
    test_max_period();
    test_buffering();
    test_independent();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule